// File: doc/BRIEF.md
# Configuration Register Bus Bridge

This bridge accepts 64-bit register accesses from a host port and forwards them to a downstream configuration-register bus. The host address is reduced to a register index. A small built-in table answers some indices locally or quietly absorbs writes to them. Every other index goes to the downstream bus at a byte address of index times eight, so that each register owns an 8-byte slot.

The host port works one access at a time. The host holds its request until the bridge returns a one-cycle ready pulse. Host data lanes are big-endian, and the downstream bus is native, so bytes are mirrored in both directions. The block has no bus-error signal. Instead, each access leaves its outcome in a sticky status pair: done alone on success, or done with fail. Software clears the pair with a strobe.

Top module: `cfgbus_bridge`

## Requirements
- R1: Only accesses with all eight byte enables set (`h_be == 8'hFF`) are accepted. Any other enable pattern is not dispatched, returns read data 0, and sets both done and fail.
- R2: The register index is host address bits [34:3]. The downstream byte address is the index shifted left by 3, on 35 bits. Host byte lane k (bits 8k+7:8k) corresponds to downstream byte 7-k, in both write data and read data.
- R3: The intercept table is consulted before dispatch. An access it handles never raises `d_req`.
- R4: A read of index 0xF000F returns the `CHIP_ID` parameter, lane-mirrored onto the host bus. A write to that index is dropped and sets done only, and a later read still returns `CHIP_ID`.
- R5: Reads of indices 0x18002, 0x1010C00, 0x1010C03, 0x90012, 0x90013, 0x90018, 0x2020007, 0x2020009 and 0x202000F return 0 locally, with done only.
- R6: Writes to indices 0x1010C00 to 0x1010C05, 0x90012, 0x90013, 0x90018, 0x2020007, 0x2020009 and 0x202000F are discarded locally, with done only.
- R7: The table is specific to direction. A read of 0x1010C01 and a write of 0x18002 are both dispatched downstream, as are any indices that are not listed.
- R8: A downstream response with `d_err` high makes a read return 0 and sets both fail and done.
- R9: A successful access, whether local or dispatched, sets done and leaves fail unchanged.
- R10: Done and fail are sticky until `st_clr`. A status event in the same cycle as `st_clr` wins over the clear.
- R11: One access is handled at a time, and `h_ready` is a one-cycle pulse. A local answer appears in the second clock after the edge that samples `h_req`. `d_req` and `d_addr` are held until `d_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req | input | 1 | Host access request, held until h_ready |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 40 | Host byte address |
| h_be | input | 8 | Host byte enables |
| h_wdata | input | 64 | Host write data, big-endian lanes |
| h_ready | output | 1 | One-cycle completion pulse |
| h_rdata | output | 64 | Host read data, valid with h_ready |
| d_req | output | 1 | Downstream request valid |
| d_ready | input | 1 | Downstream request accepted |
| d_we | output | 1 | Downstream write flag |
| d_addr | output | 35 | Downstream byte address |
| d_wdata | output | 64 | Downstream write data, native order |
| d_rsp | input | 1 | Downstream response strobe |
| d_rdata | input | 64 | Downstream read data |
| d_err | input | 1 | Downstream error with response |
| st_clr | input | 1 | Clear strobe for the status pair |
| st_done | output | 1 | Sticky done flag |
| st_fail | output | 1 | Sticky fail flag |

## Verification
A wrong intercept decision shows up within two clocks of the request. Either `d_req` rises for an index that should be local, or a listed index returns data from the downstream model instead of 0 or the chip constant. A stale latched index or direction shows up as a wrong `d_addr` or `d_we` in the same cycle as `d_req`, or as mirrored data that does not match. A status flag that is mishandled stays wrong until the next `st_clr`, so it shows up at the next access after the fault.

// File: rtl/cfgbr_pkg.sv
package cfgbr_pkg;
  localparam int WORD_BYTES = 8;
  localparam int WORD_W     = 8 * WORD_BYTES;

  typedef enum logic [2:0] {
    S_IDLE, S_DECIDE, S_ISSUE, S_WAIT, S_DONE
  } brg_state_e;

  // mirror byte lanes: byte b <-> byte WORD_BYTES-1-b
  function automatic logic [WORD_W-1:0] lane_mirror(input logic [WORD_W-1:0] v);
    logic [WORD_W-1:0] r;
    for (int b = 0; b < WORD_BYTES; b++)
      r[8*b +: 8] = v[8*(WORD_BYTES-1-b) +: 8];
    return r;
  endfunction

  function automatic logic word_complete(input logic [WORD_BYTES-1:0] be);
    return &be;
  endfunction
endpackage

// File: rtl/cfgbr_intercept.sv
module cfgbr_intercept #(
  parameter int IDX_W = 32
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             is_write,
  output logic             hit,
  output logic             give_id
);
  logic [31:0] key;
  logic        rd_zero, rd_id, wr_drop;

  assign key = 32'(idx);

  always_comb begin
    rd_id = (key == 32'h000F_000F);
    case (key)
      32'h0001_8002, 32'h0101_0C00, 32'h0101_0C03,
      32'h0009_0012, 32'h0009_0013, 32'h0009_0018,
      32'h0202_0007, 32'h0202_0009, 32'h0202_000F: rd_zero = 1'b1;
      default:                                     rd_zero = 1'b0;
    endcase
    case (key)
      32'h000F_000F,
      32'h0101_0C00, 32'h0101_0C01, 32'h0101_0C02,
      32'h0101_0C03, 32'h0101_0C04, 32'h0101_0C05,
      32'h0009_0012, 32'h0009_0013, 32'h0009_0018,
      32'h0202_0007, 32'h0202_0009, 32'h0202_000F: wr_drop = 1'b1;
      default:                                     wr_drop = 1'b0;
    endcase
  end

  assign hit     = is_write ? wr_drop : (rd_id | rd_zero);
  assign give_id = !is_write && rd_id;

  always_comb begin
    AST_ID_IMPLIES_HIT: assert (!give_id || hit); // R4
  end
endmodule

// File: rtl/cfgbr_status.sv
module cfgbr_status (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_done,
  input  logic ev_fail,
  input  logic clr,
  output logic done,
  output logic fail
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0;
      fail <= 1'b0;
    end else begin
      done <= (done && !clr) || ev_done;
      fail <= (fail && !clr) || ev_fail;
    end
  end

  AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done); // R8
  AST_STICKY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !clr |=> done); // R10
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> done); // R10
endmodule

// File: rtl/cfgbus_bridge.sv
module cfgbus_bridge #(
  parameter int          HA_W       = 40,
  parameter int          IDX_LSB    = 3,
  parameter int          IDX_W      = 32,
  parameter logic [63:0] CHIP_ID    = 64'h0123_4567_89AB_CDEF,
  parameter bit          SWAP_LANES = 1'b1,
  localparam int         DA_W       = IDX_W + IDX_LSB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            h_req,
  input  logic            h_we,
  input  logic [HA_W-1:0] h_addr,
  input  logic [7:0]      h_be,
  input  logic [63:0]     h_wdata,
  output logic            h_ready,
  output logic [63:0]     h_rdata,
  output logic            d_req,
  input  logic            d_ready,
  output logic            d_we,
  output logic [DA_W-1:0] d_addr,
  output logic [63:0]     d_wdata,
  input  logic            d_rsp,
  input  logic [63:0]     d_rdata,
  input  logic            d_err,
  input  logic            st_clr,
  output logic            st_done,
  output logic            st_fail
);
  import cfgbr_pkg::*;

  function automatic logic [DA_W-1:0] slot_addr(input logic [IDX_W-1:0] i);
    return {i, {IDX_LSB{1'b0}}};
  endfunction

  brg_state_e        state;
  logic [IDX_W-1:0]  idx_q;
  logic              we_q, full_q;
  logic [63:0]       wdata_q, rdata_q;
  logic              tbl_hit, tbl_id;
  logic [63:0]       ds_wdata, host_rd, host_id;
  logic              in_decide, in_wait;
  logic              ev_reject, ev_local, ev_resp, ev_done, ev_fail;
  logic              unused_hi;

  assign unused_hi = ^{h_addr[HA_W-1:DA_W], h_addr[IDX_LSB-1:0]};

  cfgbr_intercept #(.IDX_W(IDX_W)) u_tbl (
    .idx(idx_q), .is_write(we_q), .hit(tbl_hit), .give_id(tbl_id)
  );

  generate
    if (SWAP_LANES) begin : g_mirror
      assign ds_wdata = lane_mirror(wdata_q);
      assign host_rd  = lane_mirror(d_rdata);
      assign host_id  = lane_mirror(CHIP_ID);
    end else begin : g_direct
      assign ds_wdata = wdata_q;
      assign host_rd  = d_rdata;
      assign host_id  = CHIP_ID;
    end
  endgenerate

  assign in_decide = (state == S_DECIDE);
  assign in_wait   = (state == S_WAIT);
  assign ev_reject = in_decide && !full_q;
  assign ev_local  = in_decide && full_q && tbl_hit;
  assign ev_resp   = in_wait && d_rsp;
  assign ev_done   = ev_reject || ev_local || ev_resp;
  assign ev_fail   = ev_reject || (ev_resp && d_err);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      idx_q   <= '0;
      we_q    <= 1'b0;
      full_q  <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (h_req) begin
          idx_q   <= h_addr[IDX_LSB +: IDX_W];
          we_q    <= h_we;
          full_q  <= word_complete(h_be);
          wdata_q <= h_wdata;
          state   <= S_DECIDE;
        end
        S_DECIDE: begin
          if (ev_reject) begin
            rdata_q <= '0;
            state   <= S_DONE;
          end else if (ev_local) begin
            rdata_q <= tbl_id ? host_id : '0;
            state   <= S_DONE;
          end else begin
            state   <= S_ISSUE;
          end
        end
        S_ISSUE: if (d_ready) state <= S_WAIT;
        S_WAIT: if (d_rsp) begin
          rdata_q <= (d_err || we_q) ? '0 : host_rd;
          state   <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign h_ready = (state == S_DONE);
  assign h_rdata = rdata_q;
  assign d_req   = (state == S_ISSUE);
  assign d_we    = we_q;
  assign d_addr  = slot_addr(idx_q);
  assign d_wdata = ds_wdata;

  cfgbr_status u_st (
    .clk(clk), .rst_n(rst_n), .ev_done(ev_done), .ev_fail(ev_fail),
    .clr(st_clr), .done(st_done), .fail(st_fail)
  );

  AST_DREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    d_req && !d_ready |=> d_req && $stable(d_addr) && $stable(d_we)); // R11
  AST_LOCAL_NO_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_local |=> !d_req && h_ready); // R3
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    h_ready |=> !h_ready); // R11
  AST_ERR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ev_resp && d_err && !we_q |=> h_ready && h_rdata == '0 && st_fail); // R8
  AST_PARTIAL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> h_ready && !d_req && h_rdata == '0 && st_fail); // R1
  AST_SUCCESS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_local || (ev_resp && !d_err)) |=> st_done); // R9
endmodule

// File: tb/cfgbus_bridge_test.sv
module cfgbus_bridge_test;
  localparam logic [63:0] CID = 64'h0123_4567_89AB_CDEF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_req = 1'b0, h_we = 1'b0;
  logic [39:0] h_addr = '0;
  logic [7:0]  h_be = '0;
  logic [63:0] h_wdata = '0;
  logic        h_ready;
  logic [63:0] h_rdata;
  logic        d_req, d_we;
  logic        d_ready = 1'b0, d_rsp = 1'b0, d_err = 1'b0;
  logic [34:0] d_addr;
  logic [63:0] d_wdata, d_rdata = '0;
  logic        st_clr = 1'b0;
  logic        st_done, st_fail;

  int n_chk = 0, n_fail = 0, n_disp = 0;
  int ds_wait = 0, ds_lat = 1;
  bit ds_err = 1'b0;
  logic [34:0] cap_addr;
  logic        cap_we;
  logic [63:0] cap_wdata;

  cfgbus_bridge #(.CHIP_ID(CID)) uut (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
    .h_be(h_be), .h_wdata(h_wdata), .h_ready(h_ready), .h_rdata(h_rdata),
    .d_req(d_req), .d_ready(d_ready), .d_we(d_we), .d_addr(d_addr),
    .d_wdata(d_wdata), .d_rsp(d_rsp), .d_rdata(d_rdata), .d_err(d_err),
    .st_clr(st_clr), .st_done(st_done), .st_fail(st_fail)
  );

  always #2 clk = ~clk;

  function automatic logic [63:0] bswap(input logic [63:0] v);
    return {<<8{v}};
  endfunction
  function automatic logic [63:0] pat(input logic [34:0] a);
    return 64'hC3D2_E1F0_0000_0000 | 64'(a);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // downstream responder
  initial begin
    forever begin
      @(negedge clk);
      if (d_req) begin
        repeat (ds_wait) @(negedge clk);
        cap_addr = d_addr; cap_we = d_we; cap_wdata = d_wdata;
        d_ready = 1'b1; n_disp++;
        @(negedge clk);
        d_ready = 1'b0;
        repeat (ds_lat) @(negedge clk);
        d_rsp = 1'b1; d_err = ds_err; d_rdata = pat(cap_addr);
        @(negedge clk);
        d_rsp = 1'b0; d_err = 1'b0;
      end
    end
  end

  task automatic access(input logic we, input logic [31:0] idx, input logic [7:0] be,
                        input logic [63:0] wd, output logic [63:0] rd, output int lat);
    @(negedge clk);
    h_req = 1'b1; h_we = we; h_addr = {5'b10101, idx, 3'b000}; h_be = be; h_wdata = wd;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!h_ready && lat < 1000);
    rd = h_rdata;
    h_req = 1'b0;
  endtask

  task automatic clear_status();
    @(negedge clk); st_clr = 1'b1; @(negedge clk); st_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 reset h_ready", 64'(h_ready), 0);
    chk("R10 reset status", {62'b0, st_done, st_fail}, 0);
    chk("R3 reset d_req", 64'(d_req), 0);
  endtask

  task automatic t_chip_id();
    logic [63:0] rd; int lat; int d0;
    d0 = n_disp;
    access(1'b0, 32'h000F_000F, 8'hFF, 0, rd, lat);
    chk("R4 chip id read", rd, bswap(CID));
    chk("R11 local latency", 64'(lat), 2);
    chk("R9 done only", {62'b0, st_done, st_fail}, 64'b10);
    access(1'b1, 32'h000F_000F, 8'hFF, 64'hFFFF_0000_FFFF_0000, rd, lat);
    access(1'b0, 32'h000F_000F, 8'hFF, 0, rd, lat);
    chk("R4 id unchanged after write", rd, bswap(CID));
    chk("R3 no dispatch for id", 64'(n_disp - d0), 0);
  endtask

  task automatic t_zero_reads();
    logic [31:0] lst[9] = '{32'h18002, 32'h1010C00, 32'h1010C03, 32'h90012, 32'h90013,
                            32'h90018, 32'h2020007, 32'h2020009, 32'h202000F};
    logic [63:0] rd; int lat; int d0;
    d0 = n_disp;
    foreach (lst[i]) begin
      access(1'b0, lst[i], 8'hFF, 0, rd, lat);
      chk("R5 zero read", rd, 0);
    end
    chk("R5 zero reads local", 64'(n_disp - d0), 0);
    chk("R9 no fail after local", 64'(st_fail), 0);
  endtask

  task automatic t_absorb();
    logic [31:0] lst[12] = '{32'h1010C00, 32'h1010C01, 32'h1010C02, 32'h1010C03, 32'h1010C04,
                             32'h1010C05, 32'h90012, 32'h90013, 32'h90018, 32'h2020007,
                             32'h2020009, 32'h202000F};
    logic [63:0] rd; int lat; int d0;
    d0 = n_disp;
    foreach (lst[i]) access(1'b1, lst[i], 8'hFF, 64'h55, rd, lat);
    chk("R6 absorbed writes not dispatched", 64'(n_disp - d0), 0);
    chk("R6 absorbed done only", {62'b0, st_done, st_fail}, 64'b10);
  endtask

  task automatic t_dispatch();
    logic [63:0] rd; int lat; int d0;
    d0 = n_disp;
    access(1'b0, 32'h1010C01, 8'hFF, 0, rd, lat);
    chk("R7 read 1010C01 dispatched", 64'(n_disp - d0), 1);
    chk("R2 read slot address", 64'(cap_addr), 64'h0808_6008);
    chk("R2 read direction", 64'(cap_we), 0);
    chk("R2 read lane mirror", rd, bswap(pat(35'h0808_6008)));
    access(1'b1, 32'h18002, 8'hFF, 64'h1122_3344_5566_7788, rd, lat);
    chk("R7 write 18002 dispatched", 64'(n_disp - d0), 2);
    chk("R2 write slot address", 64'(cap_addr), 64'hC_0010);
    chk("R2 write lane mirror", cap_wdata, 64'h8877_6655_4433_2211);
    ds_wait = 3; ds_lat = 2;
    access(1'b0, 32'hFFFF_FFFF, 8'hFF, 0, rd, lat);
    chk("R2 top index address", 64'(cap_addr), 64'h7_FFFF_FFF8);
    chk("R11 stalled read data", rd, bswap(pat(35'h7_FFFF_FFF8)));
    ds_wait = 0; ds_lat = 1;
    chk("R9 dispatched done only", {62'b0, st_done, st_fail}, 64'b10);
  endtask

  task automatic t_error();
    logic [63:0] rd; int lat;
    clear_status();
    chk("R10 cleared", {62'b0, st_done, st_fail}, 0);
    ds_err = 1'b1;
    access(1'b0, 32'h0000_1234, 8'hFF, 0, rd, lat);
    ds_err = 1'b0;
    chk("R8 error read zero", rd, 0);
    chk("R8 error status", {62'b0, st_done, st_fail}, 64'b11);
    access(1'b0, 32'h000F_000F, 8'hFF, 0, rd, lat);
    chk("R10 fail sticky after success", 64'(st_fail), 1);
  endtask

  task automatic t_partial();
    logic [63:0] rd; int lat; int d0;
    clear_status();
    d0 = n_disp;
    access(1'b0, 32'h0000_2222, 8'h0F, 0, rd, lat);
    chk("R1 partial not dispatched", 64'(n_disp - d0), 0);
    chk("R1 partial read zero", rd, 0);
    chk("R1 partial status", {62'b0, st_done, st_fail}, 64'b11);
  endtask

  task automatic t_clear_race();
    // request at N0, decision at posedge 2; clear held across that edge
    @(negedge clk);
    h_req = 1'b1; h_we = 1'b0; h_addr = {5'b0, 32'h000F_000F, 3'b000}; h_be = 8'hFF;
    @(negedge clk);
    st_clr = 1'b1;
    @(negedge clk);
    st_clr = 1'b0;
    chk("R11 ready with local answer", 64'(h_ready), 1);
    h_req = 1'b0;
    chk("R10 event wins over clear", {62'b0, st_done, st_fail}, 64'b10);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_chip_id();
    t_zero_reads();
    t_absorb();
    t_dispatch();
    t_error();
    t_partial();
    t_clear_race();
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule